// File: doc/BRIEF.md
# Fractional-Code Duty-Cycle Interpolator

This block takes a wide code and drives a narrower code, two bits short, whose average over time equals the wide value. The incoming code splits into a coarse part, which is every bit except the lowest two, and a two-bit fraction. The output then toggles between the coarse value C and C+1. The fraction sets how many quarters of each repeating period sit at C+1. A downstream converter with a low-pass filter on its output can then resolve steps four times finer than its own width.

A period is made of four equal slots. Each slot lasts `SLOT_CYC` clock cycles. The C+1 slots come first and the C slots follow. A new code can be loaded at any time but is only applied at a period boundary. A one-cycle marker shows the first cycle of every period, so a consumer can line up an averaging window. The period rate is set by choosing `SLOT_CYC`. For a period rate of 10 kHz, `SLOT_CYC` is the clock frequency divided by 40 kHz.

Top module: `code_dither`

## Requirements
- R1: The coarse value is bits [17:2] of the applied code and the fraction is bits [1:0].
- R2: `codeOut` only ever shows the coarse value C of the applied code or its upper neighbour (C+1, saturated as in R7).
- R3: Slot k of a period (k = 0..3) shows the upper neighbour when k is less than the fraction, and C otherwise. Fractions 0, 1, 2 and 3 therefore give 0, 1, 2 and 3 upper slots. Each slot lasts `SLOT_CYC` cycles.
- R4: A period lasts 4*`SLOT_CYC` cycles. `periodStart` is high for its first cycle only.
- R5: A code captured on `loadStb` becomes the applied code at the first cycle of the next period. This includes a load in the final cycle of a period.
- R6: A load made partway through a period does not change `codeOut` for the rest of that period. When several loads fall within one period, the last one wins.
- R7: When C is 0xFFFF and the fraction is nonzero, the upper neighbour is 0xFFFF instead of wrapping to zero.
- R8: After reset the applied code is zero, `codeOut` is 0, and the first cycle after reset is a period start.
- R9: Except under saturation, the sum of the four slot values of a period equals the applied 18-bit code, so their mean is code/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codeIn | input | 18 | Wide code to be dithered |
| loadStb | input | 1 | Captures `codeIn` on this clock edge |
| codeOut | output | 16 | Dithered coarse code |
| periodStart | output | 1 | High in the first cycle of each period |

## Verification
The assertions assume that the applied code changes only through the period-boundary load path. They also assume that reset is held low for at least one clock edge, so that the checker's own period counter starts in step with the block. Within a period they expect the output to be either steady or to fall by exactly one, which is the single C+1-to-C step. The stimulus keeps to this by sending every load through `loadStb` and releasing reset on a falling edge. Codes are swept across every fraction for small coarse values, values around a carry, and the top of the range. Loads are placed mid-period, several within one period, and in the last cycle of a period.

// File: rtl/code_dither_pkg.sv
package code_dither_pkg;
  typedef struct packed {
    logic slotAdv;     // last cycle of a slot
    logic periodEnd;   // last cycle of a period
    logic periodBegin; // first cycle of a period
  } ctrlStrb_t;
endpackage

// File: rtl/code_dither_ctrl.sv
module code_dither_ctrl
  import code_dither_pkg::*;
#(
  parameter int FRAC_W   = 2,
  parameter int SLOT_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output ctrlStrb_t         strb,
  output logic [FRAC_W-1:0] slotIdx
);
  localparam int NSLOT = 1 << FRAC_W;
  localparam int DIV_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic slotEnd;
  logic slotHead;

  generate
    if (SLOT_CYC == 1) begin : g_nodiv
      assign slotEnd  = 1'b1;
      assign slotHead = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)        divCnt <= '0;
        else if (slotEnd) divCnt <= '0;
        else              divCnt <= divCnt + 1'b1;
      end
      assign slotEnd  = (divCnt == DIV_W'(SLOT_CYC - 1));
      assign slotHead = (divCnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)        slotIdx <= '0;
    else if (slotEnd) slotIdx <= slotIdx + 1'b1;
  end

  always_comb begin
    strb.slotAdv     = slotEnd;
    strb.periodEnd   = slotEnd && (slotIdx == FRAC_W'(NSLOT - 1));
    strb.periodBegin = slotHead && (slotIdx == '0);
  end
endmodule

// File: rtl/code_dither_path.sv
module code_dither_path
  import code_dither_pkg::*;
#(
  parameter int CODE_W = 18,
  parameter int FRAC_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CODE_W-1:0]        codeIn,
  input  logic                     loadStb,
  input  ctrlStrb_t                strb,
  input  logic [FRAC_W-1:0]        slotIdx,
  output logic [CODE_W-FRAC_W-1:0] codeOut,
  output logic [CODE_W-1:0]        activeCode
);
  localparam int COARSE_W = CODE_W - FRAC_W;

  logic [CODE_W-1:0]   pendCode;
  logic [CODE_W-1:0]   nextPend;
  logic [COARSE_W-1:0] coarse;
  logic [COARSE_W-1:0] upper;
  logic [FRAC_W-1:0]   frac;

  assign nextPend = loadStb ? codeIn : pendCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCode   <= '0;
      activeCode <= '0;
    end else begin
      pendCode <= nextPend;
      if (strb.periodEnd) activeCode <= nextPend;
    end
  end

  assign coarse = activeCode[CODE_W-1:FRAC_W];
  assign frac   = activeCode[FRAC_W-1:0];
  assign upper  = (&coarse) ? coarse : coarse + 1'b1;

  always_comb begin
    codeOut = (slotIdx < frac) ? upper : coarse;
  end
endmodule

// File: rtl/code_dither.sv
module code_dither
  import code_dither_pkg::*;
#(
  parameter int CODE_W   = 18,
  parameter int FRAC_W   = 2,
  parameter int SLOT_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CODE_W-1:0]        codeIn,
  input  logic                     loadStb,
  output logic [CODE_W-FRAC_W-1:0] codeOut,
  output logic                     periodStart
);
  ctrlStrb_t         strb;
  logic [FRAC_W-1:0] slotIdx;
  logic [CODE_W-1:0] activeCode;

  code_dither_ctrl #(.FRAC_W(FRAC_W), .SLOT_CYC(SLOT_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx)
  );

  code_dither_path #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) path_i (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .loadStb(loadStb),
    .strb(strb), .slotIdx(slotIdx), .codeOut(codeOut), .activeCode(activeCode)
  );

  assign periodStart = strb.periodBegin;
endmodule

// File: rtl/code_dither_chk.sv
module code_dither_chk #(
  parameter int CODE_W   = 18,
  parameter int FRAC_W   = 2,
  parameter int SLOT_CYC = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     periodStart,
  input logic [CODE_W-FRAC_W-1:0] codeOut,
  input logic [CODE_W-1:0]        activeCode
);
  localparam int COARSE_W = CODE_W - FRAC_W;
  localparam int PER      = SLOT_CYC << FRAC_W;
  localparam int CNT_W    = $clog2(PER) + 1;

  logic [CNT_W-1:0]    perCnt;
  logic [COARSE_W-1:0] cC;

  assign cC = activeCode[CODE_W-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (!rstN)                          perCnt <= '0;
    else if (perCnt == CNT_W'(PER - 1)) perCnt <= '0;
    else                                perCnt <= perCnt + 1'b1;
  end

  // R4
  period_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodStart == (perCnt == '0));

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> $stable(activeCode));

  // R2
  two_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == cC) || ((cC != '1) && (codeOut == cC + 1'b1)));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> (codeOut == $past(codeOut)) || (codeOut == $past(codeOut) - 1'b1));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cC == '1) |-> (codeOut == '1));
endmodule

bind code_dither code_dither_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .SLOT_CYC(SLOT_CYC)) chk_i (
  .clk(clk), .rstN(rstN), .periodStart(periodStart), .codeOut(codeOut), .activeCode(activeCode)
);

// File: tb/code_dither_tb_top.sv
`timescale 1ns/1ps
module code_dither_tb_top;
  localparam int SLOT = 4;
  localparam int PER  = 4 * SLOT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] codeIn = '0;
  logic        loadStb = 1'b0;
  logic [15:0] codeOut;
  logic        periodStart;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  code_dither #(.CODE_W(18), .FRAC_W(2), .SLOT_CYC(SLOT)) dut_i (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .loadStb(loadStb),
    .codeOut(codeOut), .periodStart(periodStart)
  );

  function automatic logic [15:0] expSlot(logic [17:0] c, int s);
    logic [15:0] co;
    co = c[17:2];
    if (s < int'(c[1:0])) return (co == 16'hFFFF) ? co : co + 16'd1;
    return co;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // At a negedge in a periodStart cycle; checks one period running code c,
  // optionally pulsing loads at given cycles (-1 for none). Ends at next period start.
  task automatic runPeriod(logic [17:0] c, int atA, logic [17:0] vA, int atB, logic [17:0] vB);
    int sum;
    sum = 0;
    for (int cyc = 0; cyc < PER; cyc++) begin
      chk("R4 periodStart", 32'(periodStart), 32'(cyc == 0));
      chk("R3/R6 slot value", 32'(codeOut), 32'(expSlot(c, cyc / SLOT)));
      if (cyc % SLOT == 0) sum += int'(codeOut);
      if (cyc == atA) begin loadStb = 1'b1; codeIn = vA; end
      else if (cyc == atB) begin loadStb = 1'b1; codeIn = vB; end
      else loadStb = 1'b0;
      @(negedge clk);
    end
    loadStb = 1'b0;
    if (c[17:2] != 16'hFFFF) chk("R9 slot sum", 32'(sum), 32'(c));
  endtask

  task automatic applyCode(logic [17:0] c);
    loadStb = 1'b1; codeIn = c;
    @(negedge clk);
    loadStb = 1'b0;
    while (!periodStart) @(negedge clk);
    runPeriod(c, -1, '0, -1, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    chk("R8 reset codeOut", 32'(codeOut), 32'd0);
    chk("R8 reset periodStart", 32'(periodStart), 32'd1);
    runPeriod(18'd0, -1, '0, -1, '0);

    // R1 R3 R9 sweeps over fractions
    for (int co = 0; co < 16; co++)
      for (int f = 0; f < 4; f++) applyCode(18'((co << 2) | f));
    applyCode(18'd4093);  // R1: coarse 1023, one upper slot
    applyCode(18'd4096);  // R1: coarse 1024, no switching
    for (int f = 0; f < 4; f++) begin
      applyCode(18'((16'h7FFF << 2) | f));
      applyCode(18'((16'h8000 << 2) | f));
      applyCode(18'((16'h0FFF << 2) | f));
    end
    // R7 saturation near top
    for (int co = 16'hFFF0; co <= 16'hFFFF; co++)
      for (int f = 0; f < 4; f++) applyCode(18'((co << 2) | f));

    // R6: two mid-period loads, last wins; current period unchanged
    applyCode(18'h00A5);
    runPeriod(18'h00A5, 3, 18'h1234B, 9, 18'h20002);
    runPeriod(18'h20002, -1, '0, -1, '0);
    // R5: load in final cycle of a period applies at the next period
    runPeriod(18'h20002, PER - 1, 18'h3FFFD, -1, '0);
    runPeriod(18'h3FFFD, -1, '0, -1, '0);
    // R5: load in first cycle still waits a whole period
    runPeriod(18'h3FFFD, 0, 18'h00007, -1, '0);
    runPeriod(18'h00007, -1, '0, -1, '0);

    finishRun();
  end
endmodule